// File: doc/BRIEF.md
# Infrared Pulse-to-Level Receive Decoder

This block turns the short optical pulses reported by an infrared transceiver into the level-coded serial stream that a UART receiver expects. All timing comes from a single-cycle enable, `tick16`, that pulses once per sixteenth of a bit time on the common system clock. The raw receive pin is first captured by a synchronizer chain that advances only on `tick16`. It then passes through an optional polarity inversion and a receive gate, and a rising-edge detector follows. Each detected edge produces one bit-time of low level, `BIT_TICKS` enables long, on `ser_out`. At all other times `ser_out` rests high.

Edges that arrive while a low period is in progress are dropped. They neither extend nor restart the period. The invert and gate controls act on the current sample and on the stored previous sample together. Changing either control while the input is steady therefore never looks like an edge. The interface has control pins only, with no data handshake. The output is a level, and it may be sampled on any `tick16`.

Top module: `irsir_pulse_decoder`

## Requirements
- R1: While `rst_n` is low, and after its release until the first detected edge, `ser_out` is 1.
- R2: When `rx_raw` (after inversion) is first sampled high on a `tick16` cycle k, having been low on the previous `tick16`, `ser_out` goes to 0 on the clock edge of the `tick16` cycle k+SYNC_STAGES.
- R3: A low period on `ser_out` lasts exactly BIT_TICKS `tick16` periods, and `ser_out` then returns to 1.
- R4: A steady input level, high or low, never starts a low period. An input held high after one rising edge gives exactly one low period.
- R5: A rising edge sampled while a low period is running is ignored. The period ends on schedule and no second period follows.
- R6: While `rx_disable` is 1, no low period starts. Releasing `rx_disable` while the input is steady high does not start one.
- R7: With `rx_invert` at 1, a falling edge of `rx_raw` starts a low period and a rising edge of `rx_raw` does not.
- R8: Toggling `rx_invert` while `rx_raw` is steady does not start a low period.
- R9: `ser_out` changes only on a clock edge where `tick16` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the baud rate |
| rx_raw | input | 1 | Asynchronous receive output of the optical transceiver |
| rx_invert | input | 1 | 1 = invert the receive signal before edge detection |
| rx_disable | input | 1 | 1 = block the receive input; the output stays idle high |
| ser_out | output | 1 | Decoded serial level, idle high |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and a sixteen-enable bit time. With these values the exact fall latency (two enables after the first high sample) and the full sixteen-enable low width can be checked against fixed counts. The enable in the bench fires every fourth clock. The idle clocks between enables therefore expose any output change that happens without `tick16`. Directed sequences cover a held-high input, a second pulse landing mid-period, polarity toggles on a quiet line, and release of the gate on a high line.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOW  = 1'b1
  } stretch_state_t;
endpackage

// File: rtl/irsir_sync.sv
module irsir_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    chain[0] <= 1'b0;
        else if (tick) chain[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    chain[g] <= 1'b0;
        else if (tick) chain[g] <= chain[g-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/irsir_edge.sv
module irsir_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync_i,
  input  logic invert_i,
  input  logic disable_i,
  output logic edge_o
);
  logic hist_q;
  logic cur_pol;
  logic prev_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist_q <= 1'b0;
    else if (tick) hist_q <= sync_i;
  end

  // Polarity and gate act on both samples alike, so a control change on a
  // steady line leaves cur_pol == prev_pol.
  assign cur_pol  = ~disable_i & (sync_i ^ invert_i);
  assign prev_pol = ~disable_i & (hist_q ^ invert_i);
  assign edge_o   = cur_pol & ~prev_pol;

  // R8: equal raw samples can never yield an edge, whatever the invert bit
  p_level_no_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i == hist_q) |-> !edge_o);
endmodule

// File: rtl/irsir_stretch.sv
module irsir_stretch
  import irsir_pkg::*;
#(
  parameter int BIT_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_i,
  output logic ser_o
);
  localparam int CNT_W = (BIT_TICKS > 2) ? $clog2(BIT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_TICKS - 1);

  stretch_state_t   st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (tick) begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q  <= ST_LOW;
            cnt_q <= '0;
          end
        end
        ST_LOW: begin
          if (cnt_q == LAST) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ser_o = (st_q == ST_IDLE);

  // R3: counter stays within one bit time and is parked at zero when idle
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (cnt_q == '0));
  // R5: a running period advances by one per enable, ignoring start_i
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOW && tick && cnt_q != LAST) |=>
      (st_q == ST_LOW && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R4: a low period starts only from an edge seen on an enable
  p_start_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_o) |-> $past(start_i && tick));
endmodule

// File: rtl/irsir_pulse_decoder.sv
module irsir_pulse_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int BIT_TICKS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic rx_raw,
  input  logic rx_invert,
  input  logic rx_disable,
  output logic ser_out
);
  logic rx_sync;
  logic rx_edge;

  irsir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick16),
    .d_i   (rx_raw),
    .q_o   (rx_sync)
  );

  irsir_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .sync_i    (rx_sync),
    .invert_i  (rx_invert),
    .disable_i (rx_disable),
    .edge_o    (rx_edge)
  );

  irsir_stretch #(.BIT_TICKS(BIT_TICKS)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .start_i (rx_edge),
    .ser_o   (ser_out)
  );

  // R9: the output moves only on enabled edges
  p_tick_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(ser_out));
  // R6: a gated receiver cannot pull the idle output low
  p_disable_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_disable && ser_out) |=> ser_out);
  // R1: output is high in the first cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> ser_out);
endmodule

// File: tb/irsir_pulse_decoder_tb_top.sv
module irsir_pulse_decoder_tb_top;
  localparam int SYNC = 2;
  localparam int BT   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rx_raw = 1'b0;
  logic rx_invert = 1'b0;
  logic rx_disable = 1'b0;
  logic ser_out;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  irsir_pulse_decoder #(.SYNC_STAGES(SYNC), .BIT_TICKS(BT)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .rx_raw     (rx_raw),
    .rx_invert  (rx_invert),
    .rx_disable (rx_disable),
    .ser_out    (ser_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // one enable pulse followed by three idle clocks; returns at a negedge
  task automatic tick_once();
    @(negedge clk) tick16 = 1'b1;
    @(negedge clk) tick16 = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks_expect_high(input int n, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      tick_once();
      if (ser_out !== 1'b1) ok = 1'b0;
    end
    check(ok, tag, ok, 1);
  endtask

  // counts enables from the start of a low period until ser_out is high
  task automatic measure_low(output int n);
    n = 0;
    for (int i = 0; i < 3 * BT; i++) begin
      tick_once();
      n++;
      if (ser_out === 1'b1) break;
    end
  endtask

  // one-enable-wide raw pulse, then wait for the expected fall
  task automatic pulse_and_fall(input string tag);
    rx_raw = 1'b1;
    tick_once();
    rx_raw = 1'b0;
    repeat (SYNC) tick_once();
    check(ser_out === 1'b0, tag, ser_out, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ser_out === 1'b1, "R1 in reset", ser_out, 1);
    rst_n = 1'b1;
    ticks_expect_high(4, "R1 after reset");
  endtask

  task automatic t_single_pulse();
    int n;
    rx_raw = 1'b1;
    tick_once();
    check(ser_out === 1'b1, "R2 before latency k", ser_out, 1);
    for (int i = 1; i < SYNC; i++) begin
      tick_once();
      check(ser_out === 1'b1, "R2 before latency", ser_out, 1);
    end
    rx_raw = 1'b0;
    repeat (3) @(negedge clk);
    check(ser_out === 1'b1, "R9 no move without enable", ser_out, 1);
    tick_once();
    check(ser_out === 1'b0, "R2 fall at k+SYNC", ser_out, 0);
    repeat (2) @(negedge clk);
    check(ser_out === 1'b0, "R9 low holds between enables", ser_out, 0);
    measure_low(n);
    check(n == BT, "R3 low width", n, BT);
    ticks_expect_high(6, "R4 idle after pulse");
  endtask

  task automatic t_held_high();
    int n;
    rx_raw = 1'b1;
    repeat (SYNC + 1) tick_once();
    check(ser_out === 1'b0, "R2 held high start", ser_out, 0);
    measure_low(n);
    check(n == BT, "R3 held high width", n, BT);
    ticks_expect_high(2 * BT, "R4 held level no repeat");
    rx_raw = 1'b0;
    ticks_expect_high(4, "R4 falling raw no pulse");
  endtask

  task automatic t_mid_period_edge();
    int n;
    pulse_and_fall("R2 first pulse");
    repeat (4) tick_once();
    rx_raw = 1'b1;
    tick_once();
    rx_raw = 1'b0;
    measure_low(n);
    check(n == BT - 5, "R5 period not extended", n, BT - 5);
    ticks_expect_high(BT + 4, "R5 second edge dropped");
  endtask

  task automatic t_disable();
    rx_disable = 1'b1;
    for (int i = 0; i < 3; i++) begin
      rx_raw = 1'b1;
      tick_once();
      rx_raw = 1'b0;
      repeat (3) tick_once();
    end
    check(ser_out === 1'b1, "R6 disabled pulses", ser_out, 1);
    rx_raw = 1'b1;
    ticks_expect_high(SYNC + 3, "R6 disabled high line");
    rx_disable = 1'b0;
    ticks_expect_high(BT, "R6 release on high line");
    rx_raw = 1'b0;
    ticks_expect_high(SYNC + 2, "R6 line returns low");
  endtask

  task automatic t_invert();
    int n;
    rx_invert = 1'b1;
    ticks_expect_high(BT, "R8 invert on, line low");
    rx_raw = 1'b1;
    ticks_expect_high(SYNC + 3, "R7 raw rise ignored when inverted");
    rx_raw = 1'b0;
    repeat (SYNC + 1) tick_once();
    check(ser_out === 1'b0, "R7 raw fall triggers", ser_out, 0);
    measure_low(n);
    check(n == BT, "R7 inverted width", n, BT);
    rx_invert = 1'b0;
    ticks_expect_high(BT, "R8 invert off, line low");
    rx_raw = 1'b1;
    repeat (SYNC + 1) tick_once();
    check(ser_out === 1'b0, "R2 rise after invert off", ser_out, 0);
    measure_low(n);
    rx_invert = 1'b1;
    ticks_expect_high(BT, "R8 invert on, line high");
    rx_invert = 1'b0;
    ticks_expect_high(BT, "R8 invert off, line high");
    rx_raw = 1'b0;
    repeat (SYNC + 1) tick_once();
  endtask

  task automatic t_back_to_back();
    int n;
    pulse_and_fall("R2 back-to-back first");
    measure_low(n);
    check(n == BT, "R3 back-to-back first width", n, BT);
    pulse_and_fall("R2 back-to-back second");
    measure_low(n);
    check(n == BT, "R3 back-to-back second width", n, BT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single_pulse();
    t_held_high();
    t_mid_period_edge();
    t_disable();
    t_invert();
    t_back_to_back();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule